// File: doc/BRIEF.md
# Return-Address Stack and Jump Unit

This unit executes the control-transfer instructions of a 32-bit register machine: plain jump, jump that saves the return address, call that saves the return address and bumps a stack index, return, and explicit push and pop of the program counter. The return-address stack lives in ordinary byte-addressed memory. The index register names the slot that the next access uses. A save stores the PC at the index and then adds four. A restore reads the word at the index and then subtracts four. The index is never adjusted before the access.

A decoder stage outside this block hands over one operation with a `start` pulse. The operation is given as a group flag and an extended opcode, together with two register numbers and their values and the current PC. The unit moves the 32-bit word through a single-port byte memory as four consecutive byte accesses, most significant byte first. In the cycle that ends the operation it presents the new PC and the updated index register for the register file to take. That cycle is marked by a one-cycle `done`. An opcode outside the supported set completes at once with `illegal` raised and nothing written.

The controller has three states. `ST_IDLE` waits for `start`. It takes the transition *launch* to `ST_XFER` for an operation that touches memory, and the transition *skip* straight to `ST_WB` for the register-only jump or an unknown code. `ST_XFER` issues one byte access per cycle. It takes *step* back to itself until the last byte has been issued, then *drain* to `ST_WB`. `ST_WB` asserts `done` and the write-back strobes, then takes *retire* back to `ST_IDLE`.

Top module: `pcstack_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with `start` low, `done`, `mem_req`, `mem_we`, `pc_we`, `reg_we` and `illegal` are all 0.
- R2: BRANCH (`op_2op`=1, `op_xop`=0x00100) stores `pc_val` at address `b_val`, then writes `pc_next`=`a_val` with `pc_we`=1. `reg_we` stays 0, so register b is unchanged.
- R3: CALL (`op_2op`=1, `op_xop`=0x00101) stores `pc_val` at address `b_val`. It writes register `b_idx` with `b_val`+4 and writes `pc_next`=`a_val`.
- R4: RET (`op_2op`=0, `op_xop`=0x01001) and POPPC (`op_2op`=0, `op_xop`=0x02001) read the word at address `a_val` into `pc_next`. They write register `a_idx` with `a_val`−4. The read uses the address before the decrement.
- R5: PUSHPC (`op_2op`=0, `op_xop`=0x02000) stores `pc_val` at address `a_val` and writes register `a_idx` with `a_val`+4. `pc_we` stays 0.
- R6: The coroutine jump (`op_2op`=0, `op_xop`=0x01000) writes `pc_next`=`a_val` with no memory access and no register write. When `start` is sampled at edge n, a memory operation holds `mem_req` high in the four cycles after edges n to n+3, and `done` is high in the cycle after edge n+4. The coroutine jump and illegal codes raise `done` in the cycle after edge n.
- R7: A word at address p occupies bytes p, p+1, p+2 and p+3, most significant byte at p. Addresses are issued in that ascending order, one per cycle. Read data arrives on `mem_rdata` one cycle after its address, and words are assembled in the same byte order.
- R8: `done` is high for exactly one cycle per operation. `pc_we`, `reg_we` and `illegal` are high only together with `done`. `mem_we` is high only together with `mem_req`.
- R9: The six codes in R2 to R6 are the only legal ones, and they are matched on all 20 bits of `op_xop` within their own group. Any other combination completes with `illegal`=1, no memory access, and `pc_we`=`reg_we`=0.
- R10: All address and index arithmetic wraps modulo 2^32, both for the byte addresses p+k and for the ±4 index update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only in `ST_IDLE` |
| op_2op | input | 1 | 1 = two-operand group, 0 = one-operand group |
| op_xop | input | 20 | Extended opcode |
| a_idx | input | 4 | Register number of operand a |
| a_val | input | 32 | Value of operand a |
| b_idx | input | 4 | Register number of operand b |
| b_val | input | 32 | Value of operand b |
| pc_val | input | 32 | Current program counter |
| mem_req | output | 1 | Byte access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after its address |
| done | output | 1 | Operation complete; write-back valid |
| illegal | output | 1 | Unknown operation code |
| pc_we | output | 1 | Load `pc_next` into the PC |
| pc_next | output | 32 | New program counter |
| reg_we | output | 1 | Write `reg_data` to register `reg_idx` |
| reg_idx | output | 4 | Register number for write-back |
| reg_data | output | 32 | Updated index value |

## Verification
Each result is due at a fixed cycle. A memory operation completes four cycles after the edge that takes `start` plus one write-back cycle, with exactly four request cycles. A register-only or unknown operation completes in the cycle right after that edge, with none. The driver stamps every expected item with that completion cycle and the expected request count. The monitor samples on falling edges and compares, at the cycle where `done` is seen, the stamp, the number of request cycles counted since the previous completion, and every write-back port. Stored words are read from the bench's memory model only after completion, and the cycle after each `done` is checked to show it has dropped.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int OPX_W = 20;

    localparam logic [OPX_W-1:0] XOP_BRANCH = 20'h00100;
    localparam logic [OPX_W-1:0] XOP_CALL   = 20'h00101;
    localparam logic [OPX_W-1:0] XOP_JUMP   = 20'h01000;
    localparam logic [OPX_W-1:0] XOP_RET    = 20'h01001;
    localparam logic [OPX_W-1:0] XOP_PUSH   = 20'h02000;
    localparam logic [OPX_W-1:0] XOP_POP    = 20'h02001;

    typedef enum logic [2:0] {
        K_BRANCH,
        K_CALL,
        K_JUMP,
        K_RET,
        K_PUSH,
        K_POP,
        K_BAD
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_WB
    } ctl_state_t;

    function automatic logic kind_touches_mem(op_kind_t k);
        return (k == K_BRANCH) || (k == K_CALL) || (k == K_RET) ||
               (k == K_PUSH)   || (k == K_POP);
    endfunction

    function automatic logic kind_stores(op_kind_t k);
        return (k == K_BRANCH) || (k == K_CALL) || (k == K_PUSH);
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
(
    input  logic             grp_two,
    input  logic [OPX_W-1:0] xop,
    output op_kind_t         kind,
    output logic             index_from_b,
    output logic             needs_mem
);

    always_comb begin
        kind = K_BAD;
        if (grp_two) begin
            unique case (xop)
                XOP_BRANCH: kind = K_BRANCH;
                XOP_CALL:   kind = K_CALL;
                default:    kind = K_BAD;
            endcase
        end else begin
            unique case (xop)
                XOP_JUMP: kind = K_JUMP;
                XOP_RET:  kind = K_RET;
                XOP_PUSH: kind = K_PUSH;
                XOP_POP:  kind = K_POP;
                default:  kind = K_BAD;
            endcase
        end
    end

    assign index_from_b = (kind == K_BRANCH) || (kind == K_CALL);
    assign needs_mem    = kind_touches_mem(kind);

endmodule

// File: rtl/pcs_addr_gen.sv
module pcs_addr_gen #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 2
) (
    input  logic [XLEN-1:0]  base,
    input  logic [CNT_W-1:0] lane,
    output logic [XLEN-1:0]  byte_addr,
    output logic [XLEN-1:0]  index_up,
    output logic [XLEN-1:0]  index_down
);

    localparam int NBYTES = XLEN / 8;
    localparam logic [XLEN-1:0] STEP = XLEN'(NBYTES);

    assign byte_addr  = base + XLEN'(lane);
    assign index_up   = base + STEP;
    assign index_down = base - STEP;

endmodule

// File: rtl/pcs_byte_lane.sv
module pcs_byte_lane #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  store_word,
    input  logic [CNT_W-1:0] lane,
    input  logic             capture,
    input  logic [7:0]       rd_byte,
    output logic [7:0]       wr_byte,
    output logic [XLEN-1:0]  load_word
);

    localparam int NBYTES = XLEN / 8;
    localparam int HOLD_W = XLEN - 8;

    logic [7:0]        slice [NBYTES];
    logic [HOLD_W-1:0] hold_q;

    for (genvar g = 0; g < NBYTES; g++) begin : g_slice
        assign slice[g] = store_word[XLEN-1-8*g -: 8];
    end

    assign wr_byte = slice[lane];

    if (NBYTES > 2) begin : g_wide
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (capture) begin
                hold_q <= {hold_q[HOLD_W-9:0], rd_byte};
            end
        end
    end else begin : g_narrow
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (capture) begin
                hold_q <= rd_byte;
            end
        end
    end

    assign load_word = {hold_q, rd_byte};

endmodule

// File: rtl/pcstack_unit.sv
module pcstack_unit
    import pcs_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_2op,
    input  logic [19:0]       op_xop,
    input  logic [RIDX_W-1:0] a_idx,
    input  logic [XLEN-1:0]   a_val,
    input  logic [RIDX_W-1:0] b_idx,
    input  logic [XLEN-1:0]   b_val,
    input  logic [XLEN-1:0]   pc_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic              illegal,
    output logic              pc_we,
    output logic [XLEN-1:0]   pc_next,
    output logic              reg_we,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [XLEN-1:0]   reg_data
);

    localparam int NBYTES = XLEN / 8;
    localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(NBYTES - 1);

    ctl_state_t        state_q;
    ctl_state_t        state_d;
    op_kind_t          kind_q;
    logic [XLEN-1:0]   base_q;
    logic [XLEN-1:0]   target_q;
    logic [XLEN-1:0]   saved_pc_q;
    logic [RIDX_W-1:0] wb_idx_q;
    logic [CNT_W-1:0]  lane_q;

    op_kind_t          dec_kind;
    logic              dec_from_b;
    logic              dec_mem;
    logic              accept;

    logic [XLEN-1:0]   byte_addr;
    logic [XLEN-1:0]   index_up;
    logic [XLEN-1:0]   index_down;
    logic [7:0]        wr_byte;
    logic [XLEN-1:0]   load_word;
    logic              capture;

    pcs_decode u_decode (
        .grp_two      (op_2op),
        .xop          (op_xop),
        .kind         (dec_kind),
        .index_from_b (dec_from_b),
        .needs_mem    (dec_mem)
    );

    pcs_addr_gen #(
        .XLEN  (XLEN),
        .CNT_W (CNT_W)
    ) u_addr (
        .base       (base_q),
        .lane       (lane_q),
        .byte_addr  (byte_addr),
        .index_up   (index_up),
        .index_down (index_down)
    );

    assign capture = (state_q == ST_XFER) && (lane_q != '0);

    pcs_byte_lane #(
        .XLEN  (XLEN),
        .CNT_W (CNT_W)
    ) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_word (saved_pc_q),
        .lane       (lane_q),
        .capture    (capture),
        .rd_byte    (mem_rdata),
        .wr_byte    (wr_byte),
        .load_word  (load_word)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // next state: launch / skip / step / drain / retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = dec_mem ? ST_XFER : ST_WB;
                end
            end
            ST_XFER: begin
                if (lane_q == LAST_LANE) begin
                    state_d = ST_WB;
                end
            end
            ST_WB: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= K_BAD;
            base_q     <= '0;
            target_q   <= '0;
            saved_pc_q <= '0;
            wb_idx_q   <= '0;
            lane_q     <= '0;
        end else if (accept) begin
            kind_q     <= dec_kind;
            base_q     <= dec_from_b ? b_val : a_val;
            target_q   <= a_val;
            saved_pc_q <= pc_val;
            wb_idx_q   <= dec_from_b ? b_idx : a_idx;
            lane_q     <= '0;
        end else if (state_q == ST_XFER) begin
            lane_q <= lane_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        illegal   = 1'b0;
        pc_we     = 1'b0;
        pc_next   = '0;
        reg_we    = 1'b0;
        reg_idx   = '0;
        reg_data  = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_XFER: begin
                mem_req  = 1'b1;
                mem_we   = kind_stores(kind_q);
                mem_addr = byte_addr;
                if (kind_stores(kind_q)) begin
                    mem_wdata = wr_byte;
                end
            end
            ST_WB: begin
                done = 1'b1;
                unique case (kind_q)
                    K_BRANCH: begin
                        pc_we   = 1'b1;
                        pc_next = target_q;
                    end
                    K_CALL: begin
                        pc_we    = 1'b1;
                        pc_next  = target_q;
                        reg_we   = 1'b1;
                        reg_idx  = wb_idx_q;
                        reg_data = index_up;
                    end
                    K_JUMP: begin
                        pc_we   = 1'b1;
                        pc_next = target_q;
                    end
                    K_RET, K_POP: begin
                        pc_we    = 1'b1;
                        pc_next  = load_word;
                        reg_we   = 1'b1;
                        reg_idx  = wb_idx_q;
                        reg_data = index_down;
                    end
                    K_PUSH: begin
                        reg_we   = 1'b1;
                        reg_idx  = wb_idx_q;
                        reg_data = index_up;
                    end
                    K_BAD: begin
                        illegal = 1'b1;
                    end
                    default: begin
                        illegal = 1'b1;
                    end
                endcase
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pcs_check.sv
module pcs_check #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic            done,
    input logic            illegal,
    input logic            pc_we,
    input logic            reg_we
);

    localparam int NBYTES = XLEN / 8;

    int unsigned req_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_run <= 0;
        end else if (mem_req) begin
            req_run <= req_run + 1;
        end else begin
            req_run <= 0;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_WE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R8

    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we || reg_we || illegal) |-> done); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + XLEN'(1))); // R7

    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (req_run < NBYTES)); // R7

    AST_REQ_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> done); // R6

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!pc_we && !reg_we && !$past(mem_req))); // R9

endmodule

bind pcstack_unit pcs_check #(.XLEN(XLEN)) u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done),
    .illegal  (illegal),
    .pc_we    (pc_we),
    .reg_we   (reg_we)
);

// File: tb/pcstack_unit_tb.sv
module pcstack_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        op_2op;
    logic [19:0] op_xop;
    logic [3:0]  a_idx;
    logic [31:0] a_val;
    logic [3:0]  b_idx;
    logic [31:0] b_val;
    logic [31:0] pc_val;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        done;
    logic        illegal;
    logic        pc_we;
    logic [31:0] pc_next;
    logic        reg_we;
    logic [3:0]  reg_idx;
    logic [31:0] reg_data;

    always #5 clk = ~clk;

    pcstack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_2op(op_2op), .op_xop(op_xop),
        .a_idx(a_idx), .a_val(a_val), .b_idx(b_idx), .b_val(b_val), .pc_val(pc_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .illegal(illegal), .pc_we(pc_we),
        .pc_next(pc_next), .reg_we(reg_we), .reg_idx(reg_idx), .reg_data(reg_data)
    );

    // byte memory with one cycle read latency
    logic [7:0] mem_model [int unsigned];

    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h00;
            if (mem_we) mem_model[mem_addr] = mem_wdata;
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [63:0] tag;
        logic        pc_we;
        logic [31:0] pc;
        logic        reg_we;
        logic [3:0]  ridx;
        logic [31:0] rval;
        logic        ill;
        int          due;
        int          nreq;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    task automatic chk(input logic [63:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic chk_mem(input logic [63:0] tag, input logic [31:0] addr,
                           input logic [31:0] expw);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] ad;
            ad = addr + 32'(k);
            w = {w[23:0], (mem_model.exists(ad) ? mem_model[ad] : 8'h00)};
        end
        chk(tag, "stored word", w, expw);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor: pops one expected item per done
    initial begin
        int   nreq;
        logic prev_done;
        exp_t e;
        nreq = 0;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                nreq = 0;
                prev_done = 1'b0;
            end else begin
                if (prev_done) chk("R8", "done one cycle", {31'b0, done}, 32'd0);
                if (mem_req) nreq++;
                if (done) begin
                    if (q.size() == 0) begin
                        chk("R8", "unexpected done", 32'd1, 32'd0);
                    end else begin
                        e = q.pop_front();
                        chk(e.tag, "done cycle", 32'(cyc), 32'(e.due));
                        chk(e.tag, "request cycles", 32'(nreq), 32'(e.nreq));
                        chk(e.tag, "pc_we", {31'b0, pc_we}, {31'b0, e.pc_we});
                        if (e.pc_we) chk(e.tag, "pc_next", pc_next, e.pc);
                        chk(e.tag, "reg_we", {31'b0, reg_we}, {31'b0, e.reg_we});
                        if (e.reg_we) begin
                            chk(e.tag, "reg_idx", {28'b0, reg_idx}, {28'b0, e.ridx});
                            chk(e.tag, "reg_data", reg_data, e.rval);
                        end
                        chk(e.tag, "illegal", {31'b0, illegal}, {31'b0, e.ill});
                    end
                    nreq = 0;
                end
                prev_done = done;
            end
        end
    end

    // driver: queue the expectation, pulse start, wait for completion
    task automatic do_op(input logic [63:0] tag, input logic two, input logic [19:0] xop,
                         input logic [3:0] ai, input logic [31:0] av,
                         input logic [3:0] bi, input logic [31:0] bv,
                         input logic [31:0] pcv,
                         input logic e_pcwe, input logic [31:0] e_pc,
                         input logic e_rwe, input logic [3:0] e_ridx, input logic [31:0] e_rval,
                         input logic e_ill, input logic uses_mem);
        exp_t e;
        @(negedge clk);
        op_2op = two; op_xop = xop; a_idx = ai; a_val = av;
        b_idx = bi; b_val = bv; pc_val = pcv;
        e.tag = tag; e.pc_we = e_pcwe; e.pc = e_pc; e.reg_we = e_rwe;
        e.ridx = e_ridx; e.rval = e_rval; e.ill = e_ill;
        e.due  = cyc + 1 + (uses_mem ? 4 : 0);
        e.nreq = uses_mem ? 4 : 0;
        q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op_2op = 1'b0; op_xop = '0;
        a_idx = '0; a_val = '0; b_idx = '0; b_val = '0; pc_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "outputs in reset",
            {26'b0, done, mem_req, mem_we, pc_we, reg_we, illegal}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset",
            {26'b0, done, mem_req, mem_we, pc_we, reg_we, illegal}, 32'd0);

        // R2 BRANCH: save at b, jump to a, b untouched
        do_op("R2", 1'b1, 20'h00100, 4'd1, 32'h0000_1000, 4'd2, 32'h0000_0200,
              32'hDEAD_BEEF, 1'b1, 32'h0000_1000, 1'b0, 4'd0, 32'd0, 1'b0, 1'b1);
        chk_mem("R7", 32'h0000_0200, 32'hDEAD_BEEF);

        // R3 CALL: save at b, b+4, jump to a
        do_op("R3", 1'b1, 20'h00101, 4'd3, 32'h0000_3000, 4'd5, 32'h0000_0300,
              32'h1234_5678, 1'b1, 32'h0000_3000, 1'b1, 4'd5, 32'h0000_0304, 1'b0, 1'b1);
        chk_mem("R3", 32'h0000_0300, 32'h1234_5678);

        // R5 PUSHPC: save at a, a+4, no pc write
        do_op("R5", 1'b0, 20'h02000, 4'd6, 32'h0000_0400, 4'd0, 32'd0,
              32'hCAFE_F00D, 1'b0, 32'd0, 1'b1, 4'd6, 32'h0000_0404, 1'b0, 1'b1);
        chk_mem("R5", 32'h0000_0400, 32'hCAFE_F00D);

        // R4 RET: read at a before decrement
        do_op("R4", 1'b0, 20'h01001, 4'd6, 32'h0000_0400, 4'd0, 32'd0,
              32'h0000_0777, 1'b1, 32'hCAFE_F00D, 1'b1, 4'd6, 32'h0000_03FC, 1'b0, 1'b1);

        // R4 POPPC
        do_op("R4", 1'b0, 20'h02001, 4'd7, 32'h0000_0300, 4'd0, 32'd0,
              32'h0000_0888, 1'b1, 32'h1234_5678, 1'b1, 4'd7, 32'h0000_02FC, 1'b0, 1'b1);

        // R6 coroutine jump: register-only, done next cycle
        do_op("R6", 1'b0, 20'h01000, 4'd1, 32'h0000_5554, 4'd2, 32'h0000_0200,
              32'h0000_0999, 1'b1, 32'h0000_5554, 1'b0, 4'd0, 32'd0, 1'b0, 1'b0);
        chk_mem("R6", 32'h0000_0200, 32'hDEAD_BEEF);

        // R9 unknown codes: nothing written, no memory access
        do_op("R9", 1'b1, 20'h00102, 4'd1, 32'h0000_0200, 4'd2, 32'h0000_0200,
              32'h1111_1111, 1'b0, 32'd0, 1'b0, 4'd0, 32'd0, 1'b1, 1'b0);
        do_op("R9", 1'b0, 20'h01002, 4'd1, 32'h0000_0200, 4'd2, 32'h0000_0200,
              32'h2222_2222, 1'b0, 32'd0, 1'b0, 4'd0, 32'd0, 1'b1, 1'b0);
        do_op("R9", 1'b1, 20'h10100, 4'd1, 32'h0000_0200, 4'd2, 32'h0000_0200,
              32'h3333_3333, 1'b0, 32'd0, 1'b0, 4'd0, 32'd0, 1'b1, 1'b0);
        do_op("R9", 1'b0, 20'h00100, 4'd1, 32'h0000_0200, 4'd2, 32'h0000_0200,
              32'h4444_4444, 1'b0, 32'd0, 1'b0, 4'd0, 32'd0, 1'b1, 1'b0);
        chk_mem("R9", 32'h0000_0200, 32'hDEAD_BEEF);

        // R10 wrap of byte addresses and of the index
        do_op("R10", 1'b0, 20'h02000, 4'd8, 32'hFFFF_FFFE, 4'd0, 32'd0,
              32'hA1B2_C3D4, 1'b0, 32'd0, 1'b1, 4'd8, 32'h0000_0002, 1'b0, 1'b1);
        chk_mem("R10", 32'hFFFF_FFFE, 32'hA1B2_C3D4);
        chk("R10", "byte at 0", {24'b0, mem_model[32'h0]}, 32'h0000_00C3);
        do_op("R10", 1'b0, 20'h02001, 4'd8, 32'hFFFF_FFFE, 4'd0, 32'd0,
              32'h0, 1'b1, 32'hA1B2_C3D4, 1'b1, 4'd8, 32'hFFFF_FFFA, 1'b0, 1'b1);
        do_op("R10", 1'b1, 20'h00101, 4'd9, 32'h0000_0040, 4'd10, 32'hFFFF_FFFC,
              32'h0BAD_CAFE, 1'b1, 32'h0000_0040, 1'b1, 4'd10, 32'h0000_0000, 1'b0, 1'b1);
        chk_mem("R10", 32'hFFFF_FFFC, 32'h0BAD_CAFE);
        do_op("R10", 1'b0, 20'h01001, 4'd11, 32'h0000_0002, 4'd0, 32'd0,
              32'h0, 1'b1, 32'h0000_0000, 1'b1, 4'd11, 32'hFFFF_FFFE, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule